// File: doc/BRIEF.md
# Big-Endian Sub-Word Load/Store Aligner

This block sits between a 32-bit register datapath and a word-wide, byte-addressed data memory. It receives one access at a time as a 6-bit operation code plus an effective byte address and a source register value. It turns that access into a single word-aligned memory request with per-byte write enables. Lanes are big-endian: the byte at word offset 0 occupies bits 31:24. For loads, it picks the addressed byte or halfword out of the returned word, moves it to the low end of the result, and extends it with zeros or copies of its sign bit. For stores, it moves the low-order byte or halfword of the source register into the addressed lane.

A small state machine sequences each access.
- `ST_IDLE` accepts a request.
- `ST_ISSUE` holds the memory request until the memory is ready.
- `ST_WAIT_RD` waits for read data.
- `ST_RESP` presents one registered load result.
- `ST_ERR` flags a rejected request.

The transitions are:
- `ST_IDLE` to `ST_ISSUE` on a legal, aligned request.
- `ST_IDLE` to `ST_ERR` on an illegal or misaligned request.
- `ST_ISSUE` to `ST_IDLE` when a store is accepted.
- `ST_ISSUE` to `ST_WAIT_RD` when a load is accepted without data.
- `ST_ISSUE` to `ST_RESP` when a load is accepted and its data arrives in the same cycle.
- `ST_WAIT_RD` to `ST_RESP` on read-valid.
- `ST_RESP` to `ST_IDLE` and `ST_ERR` to `ST_IDLE` unconditionally.

Top module: `mem_lane_aligner`

## Requirements
- R1: Lane order is big-endian. Byte offset k (address bits 1:0) selects data bits [31-8k:24-8k] and byte enable bit `mem_be[3-k]`, where `mem_be[i]` covers data bits [8i+7:8i]. A halfword at offset 0 uses bits 31:16, and a halfword at offset 2 uses bits 15:0.
- R2: Operation code 32 (signed byte load) and code 33 (signed halfword load) return the selected value at the low end of `ld_data`, with the upper bits filled by copies of its most significant bit.
- R3: Operation code 36 (unsigned byte load) and code 37 (unsigned halfword load) return the selected value at the low end of `ld_data`, with zeros above it.
- R4: Operation code 35 loads the full 32-bit word unchanged. Operation code 43 stores the full source word with `mem_be` = 4'b1111.
- R5: Operation code 40 (byte store) drives source bits 7:0 into the addressed lane with a one-hot `mem_be`. Operation code 41 (halfword store) drives source bits 15:0 into the addressed lane pair, with `mem_be` = 4'b1100 at offset 0 and 4'b0011 at offset 2. All other lanes of `mem_wdata` are zero and their enables are low.
- R6: A halfword access at an odd address, or a word access with address bits 1:0 not 00, raises `err` for exactly one cycle, in the cycle after acceptance. No memory request is made for it.
- R7: Any operation code other than the eight listed is rejected in the same way as R6.
- R8: A request is taken only while `req_ready` is high. `mem_req` then rises in the next cycle. It stays high with `mem_addr`, `mem_we`, `mem_be` and `mem_wdata` unchanged until a cycle in which `mem_ready` is high, and drops in the following cycle.
- R9: Load data is registered. `ld_valid` is high for exactly one cycle, the cycle after `mem_rvalid` is sampled high. This includes the case where `mem_rvalid` arrives in the same cycle as `mem_ready`.
- R10: During and right after reset, every output is low except `req_ready`, which is high.
- R11: `mem_addr` equals the request address with bits 1:0 cleared, and `mem_we` is high only for stores. Loads drive `mem_be` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Access request present |
| req_ready | output | 1 | Block can take a request |
| req_op | input | 6 | Operation code |
| req_addr | input | ADDR_W | Effective byte address |
| req_src | input | 32 | Source register value for stores |
| mem_req | output | 1 | Memory request |
| mem_ready | input | 1 | Memory accepts the request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | ADDR_W | Word-aligned memory address |
| mem_be | output | 4 | Per-byte write enables |
| mem_wdata | output | 32 | Lane-placed write data |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 32 | Memory read word |
| ld_valid | output | 1 | Load result strobe |
| ld_data | output | 32 | Extended load result |
| err | output | 1 | Misaligned or illegal access |

## Verification
Two things can coincide in one cycle: the memory accepting a load, and the read data for that load arriving, when a zero-latency memory raises `mem_ready` and `mem_rvalid` together. The bench provokes this on a share of both directed and random loads. It also covers the split case, where data comes one or more cycles after acceptance. In both cases the single `ld_valid` pulse must land exactly one cycle after `mem_rvalid`, and its data must match the extension computed by the bench. A missing pulse, a doubled pulse or a late pulse each count as a mismatch.

// File: rtl/mem_lane_pkg.sv
package mem_lane_pkg;

    localparam int WORD_W     = 32;
    localparam int LANE_W     = 8;
    localparam int LANES      = WORD_W / LANE_W;
    localparam int OFF_W      = $clog2(LANES);
    localparam int OPC_W      = 6;

    localparam logic [OPC_W-1:0] OPC_LD_S8  = 6'd32;
    localparam logic [OPC_W-1:0] OPC_LD_S16 = 6'd33;
    localparam logic [OPC_W-1:0] OPC_LD_32  = 6'd35;
    localparam logic [OPC_W-1:0] OPC_LD_U8  = 6'd36;
    localparam logic [OPC_W-1:0] OPC_LD_U16 = 6'd37;
    localparam logic [OPC_W-1:0] OPC_ST_8   = 6'd40;
    localparam logic [OPC_W-1:0] OPC_ST_16  = 6'd41;
    localparam logic [OPC_W-1:0] OPC_ST_32  = 6'd43;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2
    } acc_size_e;

    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_ISSUE   = 3'd1,
        ST_WAIT_RD = 3'd2,
        ST_RESP    = 3'd3,
        ST_ERR     = 3'd4
    } lane_state_e;

    typedef struct packed {
        logic      legal;
        logic      store;
        logic      sext;
        acc_size_e size;
    } acc_cmd_t;

endpackage

// File: rtl/lane_cmd_decode.sv
module lane_cmd_decode
    import mem_lane_pkg::*;
(
    input  logic [OPC_W-1:0] op,
    input  logic [OFF_W-1:0] off,
    output acc_cmd_t         cmd,
    output logic             misaligned
);

    always_comb begin
        cmd = '{legal: 1'b1, store: 1'b0, sext: 1'b0, size: SZ_WORD};
        unique case (op)
            OPC_LD_S8:  begin cmd.size = SZ_BYTE; cmd.sext = 1'b1; end
            OPC_LD_S16: begin cmd.size = SZ_HALF; cmd.sext = 1'b1; end
            OPC_LD_32:  begin cmd.size = SZ_WORD; end
            OPC_LD_U8:  begin cmd.size = SZ_BYTE; end
            OPC_LD_U16: begin cmd.size = SZ_HALF; end
            OPC_ST_8:   begin cmd.size = SZ_BYTE; cmd.store = 1'b1; end
            OPC_ST_16:  begin cmd.size = SZ_HALF; cmd.store = 1'b1; end
            OPC_ST_32:  begin cmd.size = SZ_WORD; cmd.store = 1'b1; end
            default:    begin cmd.legal = 1'b0; end
        endcase
    end

    always_comb begin
        unique case (cmd.size)
            SZ_HALF: misaligned = off[0];
            SZ_WORD: misaligned = |off;
            default: misaligned = 1'b0;
        endcase
    end

endmodule

// File: rtl/store_lane_pack.sv
module store_lane_pack
    import mem_lane_pkg::*;
(
    input  acc_size_e          size,
    input  logic [OFF_W-1:0]   off,
    input  logic [WORD_W-1:0]  src,
    output logic [LANES-1:0]   be,
    output logic [WORD_W-1:0]  wdata
);

    localparam int HALF_LANES = LANES / 2;

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        // enable bit i holds address offset LANES-1-i (big-endian)
        localparam logic [OFF_W-1:0] LANE_OFF = OFF_W'(LANES - 1 - i);
        localparam bit HI_HALF = (i >= HALF_LANES);
        logic             hit;
        logic [LANE_W-1:0] byte_src;

        always_comb begin
            unique case (size)
                SZ_BYTE: begin
                    hit      = (off == LANE_OFF);
                    byte_src = src[LANE_W-1:0];
                end
                SZ_HALF: begin
                    hit      = (off[OFF_W-1] == !HI_HALF);
                    byte_src = src[(i % 2)*LANE_W +: LANE_W];
                end
                default: begin
                    hit      = 1'b1;
                    byte_src = src[i*LANE_W +: LANE_W];
                end
            endcase
        end

        assign be[i]                     = hit;
        assign wdata[i*LANE_W +: LANE_W] = hit ? byte_src : '0;
    end

endmodule

// File: rtl/load_lane_extract.sv
module load_lane_extract
    import mem_lane_pkg::*;
(
    input  acc_size_e          size,
    input  logic               sext,
    input  logic [OFF_W-1:0]   off,
    input  logic [WORD_W-1:0]  word,
    output logic [WORD_W-1:0]  result
);

    localparam int HALF_W = 2 * LANE_W;

    logic [LANE_W-1:0] sel_b;
    logic [HALF_W-1:0] sel_h;

    always_comb begin
        sel_b = '0;
        for (int k = 0; k < LANES; k++) begin
            if (off == OFF_W'(k)) begin
                sel_b = word[(LANES-1-k)*LANE_W +: LANE_W];
            end
        end
        sel_h = off[OFF_W-1] ? word[HALF_W-1:0] : word[WORD_W-1 -: HALF_W];
    end

    always_comb begin
        unique case (size)
            SZ_BYTE: result = {{(WORD_W-LANE_W){sext & sel_b[LANE_W-1]}}, sel_b};
            SZ_HALF: result = {{(WORD_W-HALF_W){sext & sel_h[HALF_W-1]}}, sel_h};
            default: result = word;
        endcase
    end

endmodule

// File: rtl/mem_lane_aligner.sv
module mem_lane_aligner
    import mem_lane_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [5:0]        req_op,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [31:0]       req_src,
    output logic              mem_req,
    input  logic              mem_ready,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [3:0]        mem_be,
    output logic [31:0]       mem_wdata,
    input  logic              mem_rvalid,
    input  logic [31:0]       mem_rdata,
    output logic              ld_valid,
    output logic [31:0]       ld_data,
    output logic              err
);

    lane_state_e       state_q, state_d;
    acc_cmd_t          dec_cmd, cmd_q;
    logic              dec_misaligned;
    logic [ADDR_W-1:0] addr_q;
    logic [WORD_W-1:0] src_q;
    logic [WORD_W-1:0] ld_q;
    logic [LANES-1:0]  pk_be;
    logic [WORD_W-1:0] pk_wdata;
    logic [WORD_W-1:0] ext_data;
    logic              take_req;
    logic              capture_rd;

    lane_cmd_decode u_dec (
        .op         (req_op),
        .off        (req_addr[OFF_W-1:0]),
        .cmd        (dec_cmd),
        .misaligned (dec_misaligned)
    );

    store_lane_pack u_pack (
        .size  (cmd_q.size),
        .off   (addr_q[OFF_W-1:0]),
        .src   (src_q),
        .be    (pk_be),
        .wdata (pk_wdata)
    );

    load_lane_extract u_ext (
        .size   (cmd_q.size),
        .sext   (cmd_q.sext),
        .off    (addr_q[OFF_W-1:0]),
        .word   (mem_rdata),
        .result (ext_data)
    );

    assign take_req   = (state_q == ST_IDLE) && req_valid;
    assign capture_rd = mem_rvalid &&
                        (((state_q == ST_ISSUE) && mem_ready && !cmd_q.store) ||
                         (state_q == ST_WAIT_RD));

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (req_valid) begin
                    if (!dec_cmd.legal || dec_misaligned) state_d = ST_ERR;
                    else                                  state_d = ST_ISSUE;
                end
            end
            ST_ISSUE: begin
                if (mem_ready) begin
                    if (cmd_q.store)     state_d = ST_IDLE;
                    else if (mem_rvalid) state_d = ST_RESP;
                    else                 state_d = ST_WAIT_RD;
                end
            end
            ST_WAIT_RD: begin
                if (mem_rvalid) state_d = ST_RESP;
            end
            ST_RESP: state_d = ST_IDLE;
            ST_ERR:  state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // request and load-data registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmd_q  <= '{legal: 1'b0, store: 1'b0, sext: 1'b0, size: SZ_WORD};
            addr_q <= '0;
            src_q  <= '0;
            ld_q   <= '0;
        end else begin
            if (take_req) begin
                cmd_q  <= dec_cmd;
                addr_q <= req_addr;
                src_q  <= req_src;
            end
            if (capture_rd) begin
                ld_q <= ext_data;
            end
        end
    end

    // outputs
    always_comb begin
        req_ready = 1'b0;
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_be    = '0;
        mem_wdata = '0;
        ld_valid  = 1'b0;
        ld_data   = '0;
        err       = 1'b0;
        unique case (state_q)
            ST_IDLE: req_ready = 1'b1;
            ST_ISSUE: begin
                mem_req  = 1'b1;
                mem_we   = cmd_q.store;
                mem_addr = {addr_q[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
                if (cmd_q.store) begin
                    mem_be    = pk_be;
                    mem_wdata = pk_wdata;
                end
            end
            ST_WAIT_RD: ;
            ST_RESP: begin
                ld_valid = 1'b1;
                ld_data  = ld_q;
            end
            ST_ERR: err = 1'b1;
            default: ;
        endcase
    end

endmodule

// File: rtl/mem_lane_aligner_chk.sv
module mem_lane_aligner_chk #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_ready,
    input logic              mem_req,
    input logic              mem_ready,
    input logic              mem_we,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [3:0]        mem_be,
    input logic [31:0]       mem_wdata,
    input logic              mem_rvalid,
    input logic              ld_valid,
    input logic              err
);

    // R1 / R4 / R5: store enables are one lane, an aligned pair, or all four
    assert_store_be_shape_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we) |->
            (mem_be == 4'b1000 || mem_be == 4'b0100 || mem_be == 4'b0010 ||
             mem_be == 4'b0001 || mem_be == 4'b1100 || mem_be == 4'b0011 ||
             mem_be == 4'b1111));

    // R11: loads carry no byte enables and the address is word aligned
    assert_load_no_be_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_we) |-> (mem_be == 4'b0000));

    assert_word_addr_R11: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> (mem_addr[1:0] == 2'b00));

    // R6: an error is a single-cycle pulse with no memory request
    assert_err_no_req_R6: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> (!mem_req && !ld_valid));

    assert_err_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        err |=> !err);

    // R8: request fields hold until the memory takes them
    assert_req_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ready) |=>
            (mem_req && $stable(mem_addr) && $stable(mem_we) &&
             $stable(mem_be) && $stable(mem_wdata)));

    assert_ready_exclusive_R8: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (!mem_req && !ld_valid && !err));

    // R9: load strobe follows read-valid by one cycle and lasts one cycle
    assert_ld_after_rvalid_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ld_valid |-> $past(mem_rvalid));

    assert_ld_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ld_valid |=> !ld_valid);

    // R10: outputs quiet after reset
    assert_reset_quiet_R10: assert property (@(posedge clk)
        !rst_n |=> (req_ready && !mem_req && mem_be == 4'b0000 && !ld_valid && !err));

endmodule

bind mem_lane_aligner mem_lane_aligner_chk #(.ADDR_W(ADDR_W)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_ready  (req_ready),
    .mem_req    (mem_req),
    .mem_ready  (mem_ready),
    .mem_we     (mem_we),
    .mem_addr   (mem_addr),
    .mem_be     (mem_be),
    .mem_wdata  (mem_wdata),
    .mem_rvalid (mem_rvalid),
    .ld_valid   (ld_valid),
    .err        (err)
);

// File: tb/mem_lane_aligner_tb_top.sv
`timescale 1ns/1ps
module mem_lane_aligner_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [5:0]  req_op = '0;
    logic [31:0] req_addr = '0;
    logic [31:0] req_src = '0;
    logic        mem_req;
    logic        mem_ready = 1'b0;
    logic        mem_we;
    logic [31:0] mem_addr;
    logic [3:0]  mem_be;
    logic [31:0] mem_wdata;
    logic        mem_rvalid = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic        ld_valid;
    logic [31:0] ld_data;
    logic        err;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    mem_lane_aligner #(.ADDR_W(32)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_op(req_op), .req_addr(req_addr), .req_src(req_src),
        .mem_req(mem_req), .mem_ready(mem_ready), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_be(mem_be), .mem_wdata(mem_wdata),
        .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
        .ld_valid(ld_valid), .ld_data(ld_data), .err(err)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic bit f_legal(input logic [5:0] op);
        return op inside {6'd32, 6'd33, 6'd35, 6'd36, 6'd37, 6'd40, 6'd41, 6'd43};
    endfunction

    function automatic bit f_store(input logic [5:0] op);
        return op inside {6'd40, 6'd41, 6'd43};
    endfunction

    function automatic bit f_err(input logic [5:0] op, input logic [1:0] off);
        if (!f_legal(op)) return 1'b1;
        if (op inside {6'd33, 6'd37, 6'd41} && off[0]) return 1'b1;
        if (op inside {6'd35, 6'd43} && off != 2'd0) return 1'b1;
        return 1'b0;
    endfunction

    function automatic logic [31:0] f_load(input logic [5:0] op, input logic [1:0] off,
                                           input logic [31:0] w);
        logic [7:0]  b;
        logic [15:0] h;
        b = 8'(w >> (24 - 8 * int'(off)));
        h = 16'(w >> (16 - 8 * int'(off)));
        case (op)
            6'd32:   return {{24{b[7]}}, b};
            6'd36:   return {24'h0, b};
            6'd33:   return {{16{h[15]}}, h};
            6'd37:   return {16'h0, h};
            default: return w;
        endcase
    endfunction

    function automatic logic [3:0] f_be(input logic [5:0] op, input logic [1:0] off);
        case (op)
            6'd40:   return 4'(4'b1000 >> off);
            6'd41:   return (off == 2'd0) ? 4'b1100 : 4'b0011;
            6'd43:   return 4'b1111;
            default: return 4'b0000;
        endcase
    endfunction

    function automatic logic [31:0] f_wd(input logic [5:0] op, input logic [1:0] off,
                                         input logic [31:0] s);
        case (op)
            6'd40:   return {s[7:0], 24'h0} >> (8 * int'(off));
            6'd41:   return (off == 2'd0) ? {s[15:0], 16'h0} : {16'h0, s[15:0]};
            6'd43:   return s;
            default: return 32'h0;
        endcase
    endfunction

    function automatic string f_ltag(input logic [5:0] op);
        if (op == 6'd32 || op == 6'd33) return "R2 signed load (R1 lane)";
        if (op == 6'd36 || op == 6'd37) return "R3 unsigned load (R1 lane)";
        return "R4 word load";
    endfunction

    task automatic run_op(input logic [5:0] op, input logic [31:0] addr,
                          input logic [31:0] src, input logic [31:0] word,
                          input int rdy_dly, input int rv_dly, input bit same);
        logic [1:0] off = addr[1:0];
        @(negedge clk);
        chk("R8 req_ready idle", 32'(req_ready), 32'd1);
        req_valid = 1'b1; req_op = op; req_addr = addr; req_src = src;
        @(negedge clk);
        req_valid = 1'b0; req_src = ~src;
        if (f_err(op, off)) begin
            chk(f_legal(op) ? "R6 err pulse" : "R7 err pulse", 32'(err), 32'd1);
            chk(f_legal(op) ? "R6 no mem_req" : "R7 no mem_req", 32'(mem_req), 32'd0);
            @(negedge clk);
            chk("R6 err single cycle", 32'(err), 32'd0);
            return;
        end
        chk("R8 mem_req raised", 32'(mem_req), 32'd1);
        chk("R11 mem_we", 32'(mem_we), 32'(f_store(op)));
        chk("R11 mem_addr", mem_addr, {addr[31:2], 2'b00});
        chk(f_store(op) ? "R5 mem_be (R1 lane)" : "R11 load be", 32'(mem_be), 32'(f_be(op, off)));
        chk(op == 6'd43 ? "R4 word wdata" : "R5 mem_wdata", mem_wdata, f_wd(op, off, src));
        for (int i = 0; i < rdy_dly; i++) begin
            @(negedge clk);
            chk("R8 mem_req held", 32'(mem_req), 32'd1);
            chk("R8 mem_addr held", mem_addr, {addr[31:2], 2'b00});
            chk("R8 mem_wdata held", mem_wdata, f_wd(op, off, src));
        end
        mem_ready = 1'b1;
        if (!f_store(op) && same) begin
            mem_rvalid = 1'b1; mem_rdata = word;
        end
        @(negedge clk);
        mem_ready = 1'b0; mem_rvalid = 1'b0; mem_rdata = ~word;
        chk("R8 mem_req dropped", 32'(mem_req), 32'd0);
        if (f_store(op)) begin
            chk("R8 ready after store", 32'(req_ready), 32'd1);
            return;
        end
        if (!same) begin
            chk("R9 no early ld_valid", 32'(ld_valid), 32'd0);
            for (int i = 0; i < rv_dly; i++) begin
                @(negedge clk);
                chk("R9 ld_valid waits", 32'(ld_valid), 32'd0);
            end
            mem_rvalid = 1'b1; mem_rdata = word;
            @(negedge clk);
            mem_rvalid = 1'b0; mem_rdata = ~word;
        end
        chk(same ? "R9 ld_valid same-cycle" : "R9 ld_valid", 32'(ld_valid), 32'd1);
        chk(f_ltag(op), ld_data, f_load(op, off, word));
        @(negedge clk);
        chk("R9 ld_valid single cycle", 32'(ld_valid), 32'd0);
        chk("R8 ready after load", 32'(req_ready), 32'd1);
    endtask

    initial begin
        logic [5:0] ops [10];
        ops = '{6'd32, 6'd33, 6'd35, 6'd36, 6'd37, 6'd40, 6'd41, 6'd43, 6'd12, 6'd34};
        void'($urandom(32'd1357));

        // R10: reset state
        @(negedge clk);
        chk("R10 req_ready in reset", 32'(req_ready), 32'd1);
        chk("R10 mem_req in reset", 32'(mem_req), 32'd0);
        chk("R10 mem_be in reset", 32'(mem_be), 32'd0);
        chk("R10 ld_valid in reset", 32'(ld_valid), 32'd0);
        chk("R10 err in reset", 32'(err), 32'd0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R10 quiet after reset", {mem_wdata[30:0], err}, 32'd0);

        // directed: every legal code at every offset, sign-bit patterns
        for (int o = 0; o < 8; o++) begin
            for (int k = 0; k < 4; k++) begin
                run_op(ops[o], 32'h1000_0000 + 32'(k), 32'hC3A5_96F1, 32'h81FF_7E00, 0, 0, 1'b0);
                run_op(ops[o], 32'h2000_0100 + 32'(k), 32'h1234_5678, 32'h7F80_0180, 1, 1, 1'b1);
            end
        end
        // illegal codes (R7)
        run_op(6'd12, 32'h0, 32'h0, 32'h0, 0, 0, 1'b0);
        run_op(6'd34, 32'h4, 32'h0, 32'h0, 0, 0, 1'b0);
        // long memory stall
        run_op(6'd41, 32'h0000_0042, 32'hAAAA_BEEF, 32'h0, 6, 0, 1'b0);
        run_op(6'd33, 32'h0000_0040, 32'h0, 32'h8001_0002, 5, 4, 1'b0);

        // constrained random
        for (int n = 0; n < 300; n++) begin
            logic [5:0] op;
            op = ($urandom % 16 == 0) ? ops[8 + ($urandom % 2)] : ops[$urandom % 8];
            run_op(op, $urandom, $urandom, $urandom,
                   int'($urandom % 4), int'($urandom % 3), 1'($urandom % 3 == 0));
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL R8 watchdog actual=hung expected=complete");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule